// File: doc/BRIEF.md
# Power-of-Two Block Allocator

This block hands out regions of a memory pool whose sizes are powers of two. The pool is a single block of the largest order. A request names a size in units. The allocator finds the smallest order that holds that size and returns the base offset of a free block of that order. When no free block of that exact order exists, it takes the smallest larger free block and halves it repeatedly. On each split it keeps the lower half and leaves the upper half free. A release names an offset and an order. The block returns to the pool and joins with its buddy, the block at offset XOR 2^order, whenever the buddy is entirely free. Joining continues upward until a buddy is busy or the whole pool is one block again.

Allocation and release each use their own valid/ready request and response channel. The engine runs a multi-cycle state machine and handles one tree level per cycle. Both request channels hold ready low from the acceptance of an operation until its response has been taken. The free state is kept on chip as two bit vectors per tree level. One marks blocks that are free as a whole. The other marks blocks that are currently granted.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole pool is one free block of the maximum order, both request readys are high and both response valids are low.
- R2: A request of size s is served at the smallest order k no lower than MIN_ORDER with 2^k >= s, and the response carries k in its order field. A size of 0 is served as one minimum block.
- R3: When a free block of the needed order exists it is granted without any split, choosing the lowest free offset at that order.
- R4: Otherwise the smallest free order above the needed one is split. The lowest-offset block at that order is halved until it reaches the needed order, the lower half is granted, and every upper half stays free for later requests.
- R5: A released block merges with its buddy (offset XOR 2^k) while the buddy is wholly free, repeating up to the maximum order. After everything is released, a full-pool request succeeds at offset 0.
- R6: A size above 2^MAX_ORDER, or a request with no free block large enough, gets a response with the fail bit set and leaves the free state unchanged.
- R7: A release is rejected with the error bit set, and has no effect, in four cases: the order is outside MIN_ORDER..MAX_ORDER, the offset is not a multiple of 2^order, the block is not currently granted at that order, or the block was already released.
- R8: Both request readys are low from an accepted request until its response is taken. A response holds valid and its data stable while its ready is low. When both request valids are high in the same idle cycle, the allocation is taken first.
- R9: Every granted offset is a multiple of 2^order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req_valid | input | 1 | Allocation request present |
| alloc_req_ready | output | 1 | Engine can take an allocation |
| alloc_req_size | input | REQ_W | Requested size in units |
| alloc_rsp_valid | output | 1 | Allocation result present |
| alloc_rsp_ready | input | 1 | Consumer takes the allocation result |
| alloc_rsp_offset | output | MAX_ORDER | Base offset of the granted block |
| alloc_rsp_order | output | ORD_W | Order of the granted block |
| alloc_rsp_fail | output | 1 | Request could not be served |
| free_req_valid | input | 1 | Release request present |
| free_req_ready | output | 1 | Engine can take a release |
| free_req_offset | input | MAX_ORDER | Base offset of the block released |
| free_req_order | input | ORD_W | Order of the block released |
| free_rsp_valid | output | 1 | Release result present |
| free_rsp_ready | input | 1 | Consumer takes the release result |
| free_rsp_error | output | 1 | Release was rejected and ignored |

## Verification
The bench drives a directed sequence that fills the 32-unit pool with mixed orders, so that both the exact-fit path and the multi-level split path are used. An allocator that granted the upper half, or that split a larger block than needed, would return offsets that differ from the scoreboard's.

The sequence then releases the blocks in an order that leaves merges blocked at several levels before a final full-pool request. A merge that skipped the busy-buddy test, or stopped too early, would make that request fail or return a wrong offset.

Misaligned, wrong-order, out-of-range and repeated releases are each followed by allocations whose offsets reveal any stray change to the free state. A simultaneous allocate and release against a fully granted pool shows whether the allocation is taken first: with the wrong priority, the allocation would succeed.

// File: rtl/buddy_pkg.sv
`timescale 1ns/1ps
package buddy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SPLIT,
        ST_MERGE,
        ST_RSP_A,
        ST_RSP_F
    } eng_state_e;
endpackage

// File: rtl/buddy_order_calc.sv
`timescale 1ns/1ps
module buddy_order_calc #(
    parameter int MIN_ORDER = 0,
    parameter int MAX_ORDER = 5,
    parameter int REQ_W     = 8,
    parameter int ORD_W     = 3
) (
    input  logic [REQ_W-1:0] size_i,
    output logic [ORD_W-1:0] order_o,
    output logic             too_big_o
);
    localparam int CMP_W = ((REQ_W > MAX_ORDER + 1) ? REQ_W : MAX_ORDER + 1) + 1;

    logic [CMP_W-1:0] size_ext;

    always_comb begin
        size_ext  = CMP_W'(size_i);
        too_big_o = size_ext > (CMP_W'(1) << MAX_ORDER);
        order_o   = ORD_W'(MAX_ORDER);
        // walk downward so the last hit is the smallest fitting order
        for (int k = MAX_ORDER; k >= MIN_ORDER; k--) begin
            if ((CMP_W'(1) << k) >= size_ext) begin
                order_o = ORD_W'(k);
            end
        end
    end
endmodule

// File: rtl/buddy_low_pick.sv
`timescale 1ns/1ps
module buddy_low_pick #(
    parameter int W  = 32,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/buddy_free_check.sv
`timescale 1ns/1ps
module buddy_free_check #(
    parameter int MIN_ORDER = 0,
    parameter int MAX_ORDER = 5,
    parameter int DEPTH     = MAX_ORDER - MIN_ORDER,
    parameter int LEAVES    = 1 << DEPTH,
    parameter int OFS_W     = MAX_ORDER,
    parameter int ORD_W     = $clog2(MAX_ORDER + 1),
    parameter int IDX_W     = DEPTH,
    parameter int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic [OFS_W-1:0]              ofs_i,
    input  logic [ORD_W-1:0]              ord_i,
    input  logic [DEPTH:0][LEAVES-1:0]    used_i,
    output logic                          ok_o,
    output logic [LVL_W-1:0]              lvl_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic             in_range;
    logic             aligned;
    logic [OFS_W-1:0] low_mask;
    logic             held;

    always_comb begin
        in_range = (int'(ord_i) >= MIN_ORDER) && (int'(ord_i) <= MAX_ORDER);
        low_mask = (OFS_W'(1) << ord_i) - OFS_W'(1);
        aligned  = (ofs_i & low_mask) == '0;
        lvl_o    = in_range ? LVL_W'(int'(ord_i) - MIN_ORDER) : '0;
        idx_o    = IDX_W'(ofs_i >> ord_i);
        held     = in_range ? used_i[lvl_o][idx_o] : 1'b0;
        ok_o     = in_range && aligned && held;
    end
endmodule

// File: rtl/buddy_alloc.sv
`timescale 1ns/1ps
module buddy_alloc
    import buddy_pkg::*;
#(
    parameter int MIN_ORDER = 0,
    parameter int MAX_ORDER = 5,
    parameter int REQ_W     = 8,
    parameter int ORD_W     = $clog2(MAX_ORDER + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req_valid,
    output logic                 alloc_req_ready,
    input  logic [REQ_W-1:0]     alloc_req_size,
    output logic                 alloc_rsp_valid,
    input  logic                 alloc_rsp_ready,
    output logic [MAX_ORDER-1:0] alloc_rsp_offset,
    output logic [ORD_W-1:0]     alloc_rsp_order,
    output logic                 alloc_rsp_fail,
    input  logic                 free_req_valid,
    output logic                 free_req_ready,
    input  logic [MAX_ORDER-1:0] free_req_offset,
    input  logic [ORD_W-1:0]     free_req_order,
    output logic                 free_rsp_valid,
    input  logic                 free_rsp_ready,
    output logic                 free_rsp_error
);
    localparam int DEPTH  = MAX_ORDER - MIN_ORDER;
    localparam int LEAVES = 1 << DEPTH;
    localparam int IDX_W  = (DEPTH > 0) ? DEPTH : 1;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int OFS_W  = MAX_ORDER;
    localparam int CMP_W  = ((REQ_W > MAX_ORDER + 1) ? REQ_W : MAX_ORDER + 1) + 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        eng_state_e                 st;
        logic [LVL_W-1:0]           lvl;
        logic [LVL_W-1:0]           tgt;
        logic [IDX_W-1:0]           idx;
        logic [DEPTH:0][LEAVES-1:0] free_map;
        logic [DEPTH:0][LEAVES-1:0] used_map;
        logic [OFS_W-1:0]           rsp_ofs;
        logic [ORD_W-1:0]           rsp_ord;
        logic                       rsp_flag;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [OFS_W-1:0] base_of(input logic [LVL_W-1:0] lv,
                                                 input logic [IDX_W-1:0] ix);
        return OFS_W'(ix) << (int'(lv) + MIN_ORDER);
    endfunction

    function automatic logic [IDX_W-1:0] upper_child(input logic [IDX_W-1:0] ix);
        return IDX_W'({ix, 1'b1});
    endfunction

    // size to order
    logic [ORD_W-1:0] calc_ord;
    logic             calc_big;

    buddy_order_calc #(
        .MIN_ORDER (MIN_ORDER),
        .MAX_ORDER (MAX_ORDER),
        .REQ_W     (REQ_W),
        .ORD_W     (ORD_W)
    ) u_order (
        .size_i    (alloc_req_size),
        .order_o   (calc_ord),
        .too_big_o (calc_big)
    );

    // lowest free block at the level being scanned
    logic [LEAVES-1:0] pick_vec;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;

    assign pick_vec = eng_q.free_map[eng_q.lvl];

    buddy_low_pick #(
        .W  (LEAVES),
        .IW (IDX_W)
    ) u_pick (
        .vec_i (pick_vec),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // release request validation
    logic             chk_ok;
    logic [LVL_W-1:0] chk_lvl;
    logic [IDX_W-1:0] chk_idx;

    buddy_free_check #(
        .MIN_ORDER (MIN_ORDER),
        .MAX_ORDER (MAX_ORDER),
        .DEPTH     (DEPTH),
        .LEAVES    (LEAVES),
        .OFS_W     (OFS_W),
        .ORD_W     (ORD_W),
        .IDX_W     (IDX_W),
        .LVL_W     (LVL_W)
    ) u_check (
        .ofs_i  (free_req_offset),
        .ord_i  (free_req_order),
        .used_i (eng_q.used_map),
        .ok_o   (chk_ok),
        .lvl_o  (chk_lvl),
        .idx_o  (chk_idx)
    );

    logic             idle;
    logic [IDX_W-1:0] buddy_idx;

    always_comb begin
        eng_d     = eng_q;
        idle      = eng_q.st == ST_IDLE;
        buddy_idx = eng_q.idx ^ IDX_W'(1);

        alloc_req_ready  = idle;
        free_req_ready   = idle && !alloc_req_valid;
        alloc_rsp_valid  = eng_q.st == ST_RSP_A;
        free_rsp_valid   = eng_q.st == ST_RSP_F;
        alloc_rsp_offset = eng_q.rsp_ofs;
        alloc_rsp_order  = eng_q.rsp_ord;
        alloc_rsp_fail   = eng_q.rsp_flag;
        free_rsp_error   = eng_q.rsp_flag;

        unique case (eng_q.st)
            ST_IDLE: begin
                if (alloc_req_valid) begin
                    eng_d.rsp_ord = calc_ord;
                    eng_d.rsp_ofs = '0;
                    if (calc_big) begin
                        eng_d.rsp_flag = 1'b1;
                        eng_d.st       = ST_RSP_A;
                    end else begin
                        eng_d.rsp_flag = 1'b0;
                        eng_d.tgt      = LVL_W'(int'(calc_ord) - MIN_ORDER);
                        eng_d.lvl      = LVL_W'(int'(calc_ord) - MIN_ORDER);
                        eng_d.st       = ST_SCAN;
                    end
                end else if (free_req_valid) begin
                    if (!chk_ok) begin
                        eng_d.rsp_flag = 1'b1;
                        eng_d.st       = ST_RSP_F;
                    end else begin
                        eng_d.used_map[chk_lvl][chk_idx] = 1'b0;
                        eng_d.lvl      = chk_lvl;
                        eng_d.idx      = chk_idx;
                        eng_d.rsp_flag = 1'b0;
                        eng_d.st       = ST_MERGE;
                    end
                end
            end

            ST_SCAN: begin
                if (pick_any) begin
                    eng_d.free_map[eng_q.lvl][pick_idx] = 1'b0;
                    if (eng_q.lvl == eng_q.tgt) begin
                        eng_d.used_map[eng_q.lvl][pick_idx] = 1'b1;
                        eng_d.rsp_ofs = base_of(eng_q.lvl, pick_idx);
                        eng_d.st      = ST_RSP_A;
                    end else begin
                        eng_d.free_map[eng_q.lvl - 1'b1][upper_child(pick_idx)] = 1'b1;
                        eng_d.lvl = eng_q.lvl - 1'b1;
                        eng_d.idx = IDX_W'({pick_idx, 1'b0});
                        eng_d.st  = ST_SPLIT;
                    end
                end else if (eng_q.lvl == TOP_LVL) begin
                    eng_d.rsp_flag = 1'b1;
                    eng_d.st       = ST_RSP_A;
                end else begin
                    eng_d.lvl = eng_q.lvl + 1'b1;
                end
            end

            ST_SPLIT: begin
                if (eng_q.lvl == eng_q.tgt) begin
                    eng_d.used_map[eng_q.lvl][eng_q.idx] = 1'b1;
                    eng_d.rsp_ofs = base_of(eng_q.lvl, eng_q.idx);
                    eng_d.st      = ST_RSP_A;
                end else begin
                    eng_d.free_map[eng_q.lvl - 1'b1][upper_child(eng_q.idx)] = 1'b1;
                    eng_d.lvl = eng_q.lvl - 1'b1;
                    eng_d.idx = IDX_W'({eng_q.idx, 1'b0});
                end
            end

            ST_MERGE: begin
                if (eng_q.lvl != TOP_LVL && eng_q.free_map[eng_q.lvl][buddy_idx]) begin
                    eng_d.free_map[eng_q.lvl][buddy_idx] = 1'b0;
                    eng_d.lvl = eng_q.lvl + 1'b1;
                    eng_d.idx = eng_q.idx >> 1;
                end else begin
                    eng_d.free_map[eng_q.lvl][eng_q.idx] = 1'b1;
                    eng_d.st = ST_RSP_F;
                end
            end

            ST_RSP_A: begin
                if (alloc_rsp_ready) eng_d.st = ST_IDLE;
            end

            ST_RSP_F: begin
                if (free_rsp_ready) eng_d.st = ST_IDLE;
            end

            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q                   <= '0;
            eng_q.st                <= ST_IDLE;
            eng_q.free_map[DEPTH][0] <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    // ---------------- assertions ----------------
    logic [OFS_W-1:0] rsp_low_mask;
    assign rsp_low_mask = (OFS_W'(1) << alloc_rsp_order) - OFS_W'(1);

    assert_order_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_valid && alloc_req_ready && !calc_big)
        |-> ((CMP_W'(1) << calc_ord) >= CMP_W'(alloc_req_size)));

    assert_map_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.free_map & eng_q.used_map) == '0);

    assert_oversize_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_valid && alloc_req_ready && calc_big)
        |=> (alloc_rsp_valid && alloc_rsp_fail && $stable(eng_q.free_map)));

    assert_bad_free_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (free_req_valid && free_req_ready && !chk_ok)
        |=> (free_rsp_valid && free_rsp_error
             && $stable(eng_q.free_map) && $stable(eng_q.used_map)));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_req_valid && alloc_req_ready) || (free_req_valid && free_req_ready))
        |=> (!alloc_req_ready && !free_req_ready));

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_rsp_valid && !alloc_rsp_ready)
        |=> (alloc_rsp_valid && $stable(alloc_rsp_offset) && $stable(alloc_rsp_fail)));

    assert_grant_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_rsp_valid && !alloc_rsp_fail)
        |-> ((alloc_rsp_offset & rsp_low_mask) == '0));
endmodule

// File: tb/buddy_alloc_tb.sv
`timescale 1ns/1ps
module buddy_alloc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req_valid = 1'b0;
    logic       alloc_req_ready;
    logic [7:0] alloc_req_size = '0;
    logic       alloc_rsp_valid;
    logic       alloc_rsp_ready;
    logic [4:0] alloc_rsp_offset;
    logic [2:0] alloc_rsp_order;
    logic       alloc_rsp_fail;
    logic       free_req_valid = 1'b0;
    logic       free_req_ready;
    logic [4:0] free_req_offset = '0;
    logic [2:0] free_req_order = '0;
    logic       free_rsp_valid;
    logic       free_rsp_ready;
    logic       free_rsp_error;

    always #4 clk = ~clk;

    buddy_alloc u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .alloc_req_valid  (alloc_req_valid),
        .alloc_req_ready  (alloc_req_ready),
        .alloc_req_size   (alloc_req_size),
        .alloc_rsp_valid  (alloc_rsp_valid),
        .alloc_rsp_ready  (alloc_rsp_ready),
        .alloc_rsp_offset (alloc_rsp_offset),
        .alloc_rsp_order  (alloc_rsp_order),
        .alloc_rsp_fail   (alloc_rsp_fail),
        .free_req_valid   (free_req_valid),
        .free_req_ready   (free_req_ready),
        .free_req_offset  (free_req_offset),
        .free_req_order   (free_req_order),
        .free_rsp_valid   (free_rsp_valid),
        .free_rsp_ready   (free_rsp_ready),
        .free_rsp_error   (free_rsp_error)
    );

    typedef struct {
        bit       is_alloc;
        bit       bad;
        int       ofs;
        int       ord;
        string    tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   stall_left = 0;
    bit   stalled = 0;
    bit   stall_bad = 0;
    int   held_ofs = 0;
    bit   held_flag = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // monitor: pops expected items and compares as responses appear
    initial begin
        alloc_rsp_ready = 1'b0;
        free_rsp_ready  = 1'b0;
        forever begin
            @(negedge clk);
            alloc_rsp_ready = 1'b0;
            free_rsp_ready  = 1'b0;
            if (rst_n && (alloc_rsp_valid || free_rsp_valid)) begin
                if (stall_left > 0) begin
                    if (!stalled) begin
                        stalled   = 1'b1;
                        held_ofs  = int'(alloc_rsp_offset);
                        held_flag = alloc_rsp_fail;
                    end else if (!alloc_rsp_valid || int'(alloc_rsp_offset) != held_ofs
                                 || alloc_rsp_fail != held_flag) begin
                        stall_bad = 1'b1;
                    end
                    stall_left--;
                end else begin
                    exp_t e;
                    if (stalled) begin
                        if (int'(alloc_rsp_offset) != held_ofs) stall_bad = 1'b1;
                        chk(!stall_bad, "R8", "response held while stalled", int'(stall_bad), 0);
                        stalled   = 1'b0;
                        stall_bad = 1'b0;
                    end
                    if (sb_q.size() == 0) begin
                        chk(1'b0, "R8", "unexpected response", 1, 0);
                    end else begin
                        e = sb_q.pop_front();
                        chk(alloc_rsp_valid == e.is_alloc, e.tag, "response channel",
                            int'(alloc_rsp_valid), int'(e.is_alloc));
                        if (alloc_rsp_valid) begin
                            chk(alloc_rsp_fail == e.bad, e.tag, "alloc fail bit",
                                int'(alloc_rsp_fail), int'(e.bad));
                            if (!e.bad) begin
                                chk(int'(alloc_rsp_offset) == e.ofs, e.tag, "alloc offset",
                                    int'(alloc_rsp_offset), e.ofs);
                                chk(int'(alloc_rsp_order) == e.ord, e.tag, "alloc order",
                                    int'(alloc_rsp_order), e.ord);
                            end
                            alloc_rsp_ready = 1'b1;
                        end else begin
                            chk(free_rsp_error == e.bad, e.tag, "free error bit",
                                int'(free_rsp_error), int'(e.bad));
                            free_rsp_ready = 1'b1;
                        end
                    end
                end
            end
        end
    end

    task automatic do_alloc(input int size, input bit bad, input int ofs,
                            input int ord, input string tag);
        sb_q.push_back('{is_alloc: 1'b1, bad: bad, ofs: ofs, ord: ord, tag: tag});
        @(negedge clk);
        while (!alloc_req_ready) @(negedge clk);
        alloc_req_valid = 1'b1;
        alloc_req_size  = size[7:0];
        @(posedge clk);
        #1 alloc_req_valid = 1'b0;
        @(negedge clk);
        chk(!alloc_req_ready && !free_req_ready, "R8", "readys low after accept",
            int'(alloc_req_ready) + int'(free_req_ready), 0);
        wait (sb_q.size() == 0);
    endtask

    task automatic do_free(input int ofs, input int ord, input bit bad, input string tag);
        sb_q.push_back('{is_alloc: 1'b0, bad: bad, ofs: 0, ord: 0, tag: tag});
        @(negedge clk);
        while (!free_req_ready) @(negedge clk);
        free_req_valid  = 1'b1;
        free_req_offset = ofs[4:0];
        free_req_order  = ord[2:0];
        @(posedge clk);
        #1 free_req_valid = 1'b0;
        wait (sb_q.size() == 0);
    endtask

    // allocation and release raised in the same idle cycle
    task automatic do_both(input int size, input int fofs, input int ford);
        sb_q.push_back('{is_alloc: 1'b1, bad: 1'b1, ofs: 0, ord: 0, tag: "R8"});
        sb_q.push_back('{is_alloc: 1'b0, bad: 1'b0, ofs: 0, ord: 0, tag: "R8"});
        @(negedge clk);
        while (!alloc_req_ready) @(negedge clk);
        alloc_req_valid = 1'b1;
        alloc_req_size  = size[7:0];
        free_req_valid  = 1'b1;
        free_req_offset = fofs[4:0];
        free_req_order  = ford[2:0];
        @(posedge clk);
        #1 alloc_req_valid = 1'b0;
        @(negedge clk);
        chk(!free_req_ready, "R8", "release waits behind allocation", int'(free_req_ready), 0);
        while (!free_req_ready) @(negedge clk);
        @(posedge clk);
        #1 free_req_valid = 1'b0;
        wait (sb_q.size() == 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(alloc_req_ready && free_req_ready, "R1", "readys after reset",
            int'(alloc_req_ready) + int'(free_req_ready), 2);
        chk(!alloc_rsp_valid && !free_rsp_valid, "R1", "response valids after reset",
            int'(alloc_rsp_valid) + int'(free_rsp_valid), 0);

        // fill the pool
        do_alloc(1, 0, 0, 0, "R4");   // splits root down to order 0
        do_alloc(1, 0, 1, 0, "R3");
        do_alloc(3, 0, 4, 2, "R2");
        do_alloc(2, 0, 2, 1, "R3");
        do_alloc(9, 0, 16, 4, "R2");
        stall_left = 3;
        do_alloc(8, 0, 8, 3, "R3");
        do_alloc(1, 1, 0, 0, "R6");   // pool exhausted
        do_alloc(33, 1, 0, 0, "R6");  // above the pool

        // rejected releases
        do_free(1, 1, 1, "R7");       // misaligned
        do_free(0, 1, 1, "R7");       // granted at order 0, not 1
        do_free(0, 6, 1, "R7");       // order out of range
        do_free(0, 0, 0, "R5");
        do_alloc(1, 0, 0, 0, "R3");   // lowest order-0 block, state intact

        // release with blocked merges
        do_free(0, 0, 0, "R5");
        do_free(1, 0, 0, "R5");
        do_free(2, 1, 0, "R5");
        do_free(4, 2, 0, "R5");
        do_free(1, 0, 1, "R7");       // already released
        do_alloc(8, 0, 0, 3, "R5");   // merged order-3 block at 0
        do_free(0, 3, 0, "R5");
        do_free(8, 3, 0, "R5");
        do_free(16, 4, 0, "R5");
        do_alloc(32, 0, 0, 5, "R5");  // pool fully merged

        do_alloc(33, 1, 0, 0, "R6");
        do_both(1, 0, 5);             // allocation first: fails, then root freed
        do_alloc(32, 0, 0, 5, "R6");  // failures changed nothing
        do_free(0, 5, 0, "R5");

        // split from the smallest larger order
        do_alloc(0, 0, 0, 0, "R2");
        do_alloc(5, 0, 8, 3, "R3");
        do_alloc(6, 0, 16, 3, "R4");
        do_alloc(4, 0, 4, 2, "R4");
        do_alloc(7, 0, 24, 3, "R4");  // upper half left by the split
        do_free(0, 0, 0, "R5");
        do_free(8, 3, 0, "R5");
        do_free(16, 3, 0, "R5");
        do_free(4, 2, 0, "R5");
        do_free(24, 3, 0, "R5");
        do_alloc(32, 0, 0, 5, "R9");
        do_free(0, 5, 0, "R5");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule